// File: doc/BRIEF.md
# Dual Serial Temperature Sensor Reader

This block reads two identical serial temperature sensors in one transaction. The sensors share one serial clock line and one chip-select line, and each has its own data line. A request on `start_i` runs a fixed line sequence. Two idle clock pulses are sent with chip-select high. Chip-select then drops, and one clock pulse is sent for each data bit. Chip-select rises again and one final clock pulse is sent. Both sensors are sampled on the same clock pulses.

Each captured 16-bit two's-complement word becomes a signed temperature in units of 1/32 °C by dropping its two low bits. A word of all zeros or all ones means the sensor is missing or broken. In that case the sensor's result is marked invalid and reads as zero. When both results are in place, `done_o` pulses for one cycle. The results then hold until the next read completes.

Top module: `dual_temp_reader`

## Requirements
- R1: After reset `sck_o` is 0, `cs_o` is 1, `done_o` is 0, and both temperatures and both valid flags are 0. Whenever no read is running, `sck_o` is 0 and `cs_o` is 1.
- R2: A read begins with exactly two rising edges of `sck_o` while `cs_o` is 1, before `cs_o` falls.
- R3: While `cs_o` is 0 there are exactly WORD_W (16) rising edges of `sck_o`. Each data line is sampled at the end of each high phase, and the first bit is the most significant.
- R4: After `cs_o` rises again, exactly one more rising edge of `sck_o` occurs, and `sck_o` then returns to 0.
- R5: Every high phase of `sck_o` lasts exactly PHASE_CYC system-clock cycles.
- R6: For a captured word other than 0x0000 or 0xFFFF, the valid flag is 1 and the temperature is the word's bits [15:2] read as a signed 14-bit value (1/32 °C per step).
- R7: A captured word of 0x0000 or 0xFFFF sets that sensor's valid flag to 0 and its temperature to 0. The other sensor is not affected.
- R8: `done_o` is high for exactly one cycle, 40·PHASE_CYC+1 cycles after the cycle in which `start_i` was driven high while idle.
- R9: A pulse on `start_i` during a read is ignored. That read completes once with its own data, and no second read follows.
- R10: Temperatures and valid flags change only in the cycle in which `done_o` is high, and they hold their values between reads. `cs_o` changes only while `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one read of both sensors |
| sdi_a_i | input | 1 | Serial data from sensor A |
| sdi_b_i | input | 1 | Serial data from sensor B |
| sck_o | output | 1 | Shared serial clock |
| cs_o | output | 1 | Shared chip-select, low while data is clocked |
| done_o | output | 1 | One-cycle pulse when both results are updated |
| temp_a_o | output | 14 | Sensor A temperature, signed, 1/32 °C |
| temp_b_o | output | 14 | Sensor B temperature, signed, 1/32 °C |
| valid_a_o | output | 1 | Sensor A result is valid |
| valid_b_o | output | 1 | Sensor B result is valid |

## Verification
The assertions assume the sensors change their data only after a falling serial clock. They also assume `start_i` is a synchronous level, and they put no limit on when it is pulsed. The sensor models in the bench follow this: each presents its most significant bit when chip-select falls and advances one bit on each falling serial clock while chip-select is low. The extra start pulse is placed in the middle of a read, so the ignore rule is exercised without breaking the data framing.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  // Phase map of one read, w = word width:
  // 0..3       : two clock pulses, chip-select high
  // 4          : chip-select low, clock low (setup)
  // 5..2w+4    : w data pulses (odd phases high)
  // 2w+5       : chip-select high, clock low
  // 2w+6,2w+7  : one trailing pulse
  function automatic int last_phase(input int w);
    return 2 * w + 7;
  endfunction

  function automatic logic phase_sck(input int p, input int w);
    if (p < 4)
      return (p % 2 == 0);
    else if (p >= 5 && p <= 2 * w + 4)
      return (p % 2 == 1);
    else
      return (p == 2 * w + 6);
  endfunction

  function automatic logic phase_cs(input int p, input int w);
    return !(p >= 4 && p <= 2 * w + 4);
  endfunction

  function automatic logic phase_sample(input int p, input int w);
    return (p >= 5) && (p <= 2 * w + 4) && (p % 2 == 1);
  endfunction

endpackage

// File: rtl/dtr_seq.sv
module dtr_seq
  import dtr_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int WORD_W    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic sck_o,
  output logic cs_o,
  output logic shift_o,
  output logic finish_o
);
  localparam int LAST = last_phase(WORD_W);
  localparam int PHW  = $clog2(LAST + 1);
  localparam int CW   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic [CW-1:0]  cnt;
  logic [PHW-1:0] ph;
  logic           phase_end;

  assign phase_end = busy_o && (cnt == CW'(PHASE_CYC - 1));
  assign shift_o   = phase_end && phase_sample(int'(ph), WORD_W);
  assign finish_o  = phase_end && (ph == PHW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
      ph     <= '0;
      sck_o  <= 1'b0;
      cs_o   <= 1'b1;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt    <= '0;
        ph     <= '0;
        sck_o  <= phase_sck(0, WORD_W);
        cs_o   <= phase_cs(0, WORD_W);
      end
    end else if (phase_end) begin
      cnt <= '0;
      if (ph == PHW'(LAST)) begin
        busy_o <= 1'b0;
        sck_o  <= 1'b0;
        cs_o   <= 1'b1;
      end else begin
        ph    <= ph + 1'b1;
        sck_o <= phase_sck(int'(ph) + 1, WORD_W);
        cs_o  <= phase_cs(int'(ph) + 1, WORD_W);
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dtr_lane.sv
module dtr_lane #(
  parameter int WORD_W      = 16,
  parameter int DROP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sdi_i,
  input  logic                              shift_i,
  input  logic                              finish_i,
  output logic signed [WORD_W-DROP-1:0]     temp_o,
  output logic                              valid_o
);
  localparam int TW = WORD_W - DROP;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sdi_s;
  logic [WORD_W-1:0]      raw;
  logic                   bad_code;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk)
        if (rst) sync_q <= '0;
        else     sync_q <= sdi_i;
    end else begin : g_syncn
      always_ff @(posedge clk)
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], sdi_i};
    end
  endgenerate

  assign sdi_s    = sync_q[SYNC_STAGES-1];
  assign bad_code = (raw == '0) || (raw == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw     <= '0;
      temp_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (shift_i)
        raw <= {raw[WORD_W-2:0], sdi_s};
      if (finish_i) begin
        valid_o <= !bad_code;
        temp_o  <= bad_code ? '0 : $signed(raw[WORD_W-1:DROP]);
      end
    end
  end

  initial if (TW < 2) $error("dtr_lane: word too narrow");

endmodule

// File: rtl/dual_temp_reader.sv
module dual_temp_reader #(
  parameter int PHASE_CYC   = 4,
  parameter int WORD_W      = 16,
  parameter int DROP        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int TEMP_W     = WORD_W - DROP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     sdi_a_i,
  input  logic                     sdi_b_i,
  output logic                     sck_o,
  output logic                     cs_o,
  output logic                     done_o,
  output logic signed [TEMP_W-1:0] temp_a_o,
  output logic signed [TEMP_W-1:0] temp_b_o,
  output logic                     valid_a_o,
  output logic                     valid_b_o
);
  localparam int LANES = 2;

  logic busy;
  logic shift;
  logic finish;
  logic [LANES-1:0] sdi_v;
  logic [LANES-1:0] valid_v;
  logic signed [TEMP_W-1:0] temp_v [LANES];

  assign sdi_v = {sdi_b_i, sdi_a_i};

  dtr_seq #(
    .PHASE_CYC (PHASE_CYC),
    .WORD_W    (WORD_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy),
    .sck_o    (sck_o),
    .cs_o     (cs_o),
    .shift_o  (shift),
    .finish_o (finish)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      dtr_lane #(
        .WORD_W      (WORD_W),
        .DROP        (DROP),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_lane (
        .clk      (clk),
        .rst      (rst),
        .sdi_i    (sdi_v[i]),
        .shift_i  (shift),
        .finish_i (finish),
        .temp_o   (temp_v[i]),
        .valid_o  (valid_v[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done_o <= 1'b0;
    else     done_o <= finish;
  end

  assign temp_a_o  = temp_v[0];
  assign temp_b_o  = temp_v[1];
  assign valid_a_o = valid_v[0];
  assign valid_b_o = valid_v[1];

endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
  parameter int TEMP_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              sck_o,
  input logic              cs_o,
  input logic              done_o,
  input logic [TEMP_W-1:0] temp_a_o,
  input logic [TEMP_W-1:0] temp_b_o,
  input logic              valid_a_o,
  input logic              valid_b_o
);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_o && !sck_o)); // R1

  AST_CS_EDGE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (cs_o != $past(cs_o)) |-> !sck_o); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_INVALID_A_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid_a_o |-> (temp_a_o == '0)); // R7

  AST_INVALID_B_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid_b_o |-> (temp_b_o == '0)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((temp_a_o != $past(temp_a_o)) || (temp_b_o != $past(temp_b_o))) |-> done_o); // R10

endmodule

bind dual_temp_reader dtr_checker #(.TEMP_W(TEMP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .sck_o     (sck_o),
  .cs_o      (cs_o),
  .done_o    (done_o),
  .temp_a_o  (temp_a_o),
  .temp_b_o  (temp_b_o),
  .valid_a_o (valid_a_o),
  .valid_b_o (valid_b_o)
);

// File: tb/dual_temp_reader_tb.sv
`timescale 1ns/1ps
module dual_temp_reader_tb;
  localparam int P = 4;
  localparam int READ_CYC = 40 * P + 1;
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0190_FF70, 32'h0000_1234, 32'hFFFF_8000, 32'h7FFC_0000,
    32'h0003_FFFF, 32'hFFFE_0004, 32'h0000_FFFF, 32'hA5A5_5A5A
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sdi_a_i, sdi_b_i;
  logic sck_o, cs_o, done_o, valid_a_o, valid_b_o;
  logic signed [13:0] temp_a_o, temp_b_o;

  int total = 0;
  int bad = 0;
  logic [15:0] word_a = '0, word_b = '0;
  int idx = -1;
  int pre_n = 0, data_n = 0, post_n = 0, hi_run = 0, bad_ph = 0, done_n = 0;
  logic seen_low = 1'b0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  always #5 clk = ~clk;

  dual_temp_reader #(.PHASE_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .sdi_a_i(sdi_a_i), .sdi_b_i(sdi_b_i),
    .sck_o(sck_o), .cs_o(cs_o), .done_o(done_o),
    .temp_a_o(temp_a_o), .temp_b_o(temp_b_o),
    .valid_a_o(valid_a_o), .valid_b_o(valid_b_o)
  );

  assign sdi_a_i = (idx >= 0 && idx < 16) ? word_a[idx] : 1'b0;
  assign sdi_b_i = (idx >= 0 && idx < 16) ? word_b[idx] : 1'b0;

  // sensor models and line monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (done_o) done_n <= done_n + 1;
    if (prev_cs && !cs_o) begin
      idx <= 15;
      seen_low <= 1'b1;
    end else if (prev_sck && !sck_o && !cs_o) begin
      idx <= idx - 1;
    end
    if (!prev_sck && sck_o) begin
      if (!cs_o) data_n <= data_n + 1;
      else if (seen_low) post_n <= post_n + 1;
      else pre_n <= pre_n + 1;
    end
    if (sck_o) hi_run <= hi_run + 1;
    else begin
      if (prev_sck && hi_run != P) bad_ph <= bad_ph + 1;
      hi_run <= 0;
    end
    prev_sck <= sck_o;
    prev_cs <= cs_o;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic exp_valid(input logic [15:0] r);
    return !(r == 16'h0000 || r == 16'hFFFF);
  endfunction

  function automatic logic [13:0] exp_temp(input logic [15:0] r);
    return exp_valid(r) ? r[15:2] : 14'h0;
  endfunction

  task automatic clear_mon();
    pre_n = 0; data_n = 0; post_n = 0; bad_ph = 0; seen_low = 1'b0; done_n = 0;
  endtask

  // one read; returns cycles from start to done
  task automatic run_read(input logic [15:0] a, input logic [15:0] b, input logic extra_start,
                          output int cyc);
    @(negedge clk);
    word_a = a; word_b = b; clear_mon();
    start_i = 1'b1;
    cyc = 0;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 10 * READ_CYC) begin
      if (extra_start && cyc == 60) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck_o == 0 && cs_o == 1, "R1 lines", {sck_o, cs_o}, 2'b01);
    chk(done_o == 0 && valid_a_o == 0 && valid_b_o == 0, "R1 flags",
        {done_o, valid_a_o, valid_b_o}, 0);
    chk(temp_a_o == 0 && temp_b_o == 0, "R1 temps", {temp_a_o, temp_b_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] a, b;
      a = VEC[v][31:16];
      b = VEC[v][15:0];
      run_read(a, b, 1'b0, cyc);
      chk(cyc == READ_CYC, "R8 latency", cyc, READ_CYC);
      chk(temp_a_o == exp_temp(a) && valid_a_o == exp_valid(a), "R6/R7 sensor A",
          {valid_a_o, temp_a_o}, {exp_valid(a), exp_temp(a)});
      chk(temp_b_o == exp_temp(b) && valid_b_o == exp_valid(b), "R6/R7 sensor B",
          {valid_b_o, temp_b_o}, {exp_valid(b), exp_temp(b)});
      chk(pre_n == 2, "R2 pre pulses", pre_n, 2);
      chk(data_n == 16, "R3 data pulses", data_n, 16);
      chk(post_n == 1, "R4 post pulses", post_n, 1);
      chk(bad_ph == 0, "R5 high phase length", bad_ph, 0);
      @(negedge clk);
      chk(done_o == 0, "R8 pulse width", done_o, 0);
      chk(sck_o == 0 && cs_o == 1, "R4 idle after read", {sck_o, cs_o}, 2'b01);
    end

    // R9 start during a read is ignored
    run_read(16'h0320, 16'hFC00, 1'b1, cyc);
    chk(cyc == READ_CYC, "R9 latency unchanged", cyc, READ_CYC);
    chk(temp_a_o == 14'h00C8 && temp_b_o == 14'h3F00, "R9 data",
        {temp_a_o, temp_b_o}, {14'h00C8, 14'h3F00});
    repeat (3 * READ_CYC) @(negedge clk);
    chk(done_n == 1, "R9 single done", done_n, 1);
    chk(pre_n == 2 && data_n == 16, "R9 no second read", {pre_n, data_n}, {2, 16});
    // R10 results hold between reads
    chk(temp_a_o == 14'h00C8 && valid_a_o == 1, "R10 hold A", temp_a_o, 14'h00C8);
    chk(temp_b_o == 14'h3F00 && valid_b_o == 1, "R10 hold B", temp_b_o, 14'h3F00);

    // R1 reset mid-read returns lines to idle
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    chk(sck_o == 0 && cs_o == 1 && temp_a_o == 0 && valid_b_o == 0, "R1 reset mid-read",
        {sck_o, cs_o, valid_b_o}, 3'b010);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule